// File: doc/BRIEF.md
# ECC Event Interrupt Status Unit

This unit gathers ECC events from a set of peripheral memories. Each memory reports two kinds of event: a single-bit error that was corrected, and an uncorrectable error. Every event sets a sticky bit in a status register. A per-peripheral enable register gates each sticky bit. Two combined interrupt lines come out of the unit: one for uncorrectable errors and one for corrected errors.

Each peripheral also has a saturating event counter. Software reaches every register through a plain single-cycle port: a write strobe, an address and write data. Read data is returned combinationally for the address presented.

Register map: address 0 is the status register, address 1 is the enable register, and addresses 2 to 2+NUM_PERIPH-1 hold the per-peripheral counters. In the status and enable registers, bit i (for i below NUM_PERIPH) belongs to the uncorrectable event of peripheral i. Bit NUM_PERIPH+i belongs to the corrected event of peripheral i. Counters read zero-extended in the low CNT_W bits. The register layouts need 2*NUM_PERIPH ≤ DATA_W and CNT_W ≤ DATA_W.

Top module: `ecc_irq_unit`

## Requirements
- R1: After reset, the status register, the enable register and every counter read 0, and both interrupt outputs are low.
- R2: An uncorrectable event on peripheral i sets status bit i at the next clock edge. The bit stays set until software clears it.
- R3: A corrected event on peripheral i sets status bit NUM_PERIPH+i at the next clock edge. The bit stays set until software clears it.
- R4: A write to address 0 clears each status bit where the written data holds a 1. Bits written with 0 keep their value.
- R5: An event that arrives in the same cycle as a clear of its status bit leaves that bit set.
- R6: The enable register at address 1 is read/write, uses the same bit layout as the status register, and resets to 0.
- R7: `irq_err` is high exactly when some uncorrectable status bit and its enable bit are both 1. `irq_cor` is high exactly when some corrected status bit and its enable bit are both 1. A set status bit whose enable is 0 raises no interrupt.
- R8: A counter rises by one at each clock edge where its peripheral reports an uncorrectable event, a corrected event, or both. Both events in the same cycle still count once.
- R9: A counter at its maximum value 2^CNT_W-1 stays there when further events arrive.
- R10: Writing zero to a counter's address clears that counter. Writing a nonzero value to it has no effect.
- R11: If a counter is cleared in the same cycle as an event on its peripheral, the counter reads 1 afterwards.
- R12: Reads of unmapped addresses return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ecc_err_evt | input | NUM_PERIPH | Per-peripheral uncorrectable-error event pulses |
| ecc_cor_evt | input | NUM_PERIPH | Per-peripheral corrected-error event pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr |
| irq_err | output | 1 | Combined uncorrectable-error interrupt |
| irq_cor | output | 1 | Combined corrected-error interrupt |

## Verification
The bench builds the unit with NUM_PERIPH=4, CNT_W=3 and ADDR_W=3. With a 3-bit counter, saturation at 7 is reached within a few cycles of continuous events. A 3-bit address leaves two unmapped addresses (6 and 7), so the zero read and the ignored write can be seen at the port. With four peripherals, one uncorrectable and one corrected enable can be set while neighbouring status bits stay ungated. This shows that the interrupt gating works bit by bit.

// File: rtl/ecc_irq_pkg.sv
package ecc_irq_pkg;
  localparam int unsigned ADDR_STATUS   = 0;
  localparam int unsigned ADDR_ENABLE   = 1;
  localparam int unsigned ADDR_CNT_BASE = 2;
endpackage

// File: rtl/ecc_irq_status.sv
module ecc_irq_status #(
  parameter int unsigned NP = 4,
  localparam int unsigned SW = 2 * NP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] err_evt,
  input  logic [NP-1:0] cor_evt,
  input  logic          stat_we,
  input  logic          en_we,
  input  logic [SW-1:0] wdata,
  output logic [SW-1:0] stat_q,
  output logic [SW-1:0] en_q,
  output logic          irq_err,
  output logic          irq_cor
);

  // Sticky merge: clear first, then new events win over the clear.
  function automatic logic [SW-1:0] w1c_merge(input logic [SW-1:0] cur,
                                              input logic [SW-1:0] clr_mask,
                                              input logic [SW-1:0] set_mask);
    return (cur & ~clr_mask) | set_mask;
  endfunction

  logic [SW-1:0] set_vec;
  logic [SW-1:0] clr_vec;
  logic [NP-1:0] err_hit;
  logic [NP-1:0] cor_hit;

  assign set_vec = {cor_evt, err_evt};
  assign clr_vec = stat_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      stat_q <= w1c_merge(stat_q, clr_vec, set_vec);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= wdata;
    end
  end

  assign err_hit = stat_q[NP-1:0]  & en_q[NP-1:0];
  assign cor_hit = stat_q[SW-1:NP] & en_q[SW-1:NP];
  assign irq_err = |err_hit;
  assign irq_cor = |cor_hit;

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec))); // R5
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> ((stat_q & $past(wdata & ~set_vec)) == '0)); // R4
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_we && set_vec == '0) |=> $stable(stat_q)); // R2
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> $stable(en_q)); // R6

endmodule

// File: rtl/ecc_irq_counter.sv
module ecc_irq_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  input  logic             clr_req,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // Clear applies first, then a pending event counts on top of it.
  function automatic logic [CNT_W-1:0] sat_next(input logic [CNT_W-1:0] cur,
                                                input logic             inc,
                                                input logic             clr);
    logic [CNT_W-1:0] base;
    base = clr ? '0 : cur;
    if (inc && base != CNT_MAX) begin
      return base + 1'b1;
    end
    return base;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= sat_next(cnt_q, bump, clr_req);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr_req) |=> (cnt_q == CNT_MAX)); // R9
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && !clr_req && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R8
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !bump) |=> (cnt_q == '0)); // R10
  AST_CLR_AND_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && bump) |=> (cnt_q == CNT_W'(1))); // R11

endmodule

// File: rtl/ecc_irq_unit.sv
module ecc_irq_unit #(
  parameter int unsigned NUM_PERIPH = 4,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PERIPH-1:0] ecc_err_evt,
  input  logic [NUM_PERIPH-1:0] ecc_cor_evt,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic                  irq_err,
  output logic                  irq_cor
);
  import ecc_irq_pkg::*;

  localparam int unsigned SW = 2 * NUM_PERIPH;

  logic                  sel_stat;
  logic                  sel_en;
  logic [NUM_PERIPH-1:0] sel_cnt;
  logic                  addr_hit;
  logic                  wr_zero;
  logic [SW-1:0]         stat_q;
  logic [SW-1:0]         en_q;
  logic [CNT_W-1:0]      cnt_q [NUM_PERIPH];

  assign sel_stat = (reg_addr == ADDR_W'(ADDR_STATUS));
  assign sel_en   = (reg_addr == ADDR_W'(ADDR_ENABLE));
  assign wr_zero  = (reg_wdata == '0);
  assign addr_hit = sel_stat | sel_en | (|sel_cnt);

  ecc_irq_status #(.NP(NUM_PERIPH)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .err_evt (ecc_err_evt),
    .cor_evt (ecc_cor_evt),
    .stat_we (reg_we & sel_stat),
    .en_we   (reg_we & sel_en),
    .wdata   (reg_wdata[SW-1:0]),
    .stat_q  (stat_q),
    .en_q    (en_q),
    .irq_err (irq_err),
    .irq_cor (irq_cor)
  );

  for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_cnt
    assign sel_cnt[g] = (reg_addr == ADDR_W'(ADDR_CNT_BASE + g));
    ecc_irq_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .bump    (ecc_err_evt[g] | ecc_cor_evt[g]),
      .clr_req (reg_we & sel_cnt[g] & wr_zero),
      .cnt_q   (cnt_q[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_stat) reg_rdata[SW-1:0] = stat_q;
    if (sel_en)   reg_rdata[SW-1:0] = en_q;
    for (int i = 0; i < NUM_PERIPH; i++) begin
      if (sel_cnt[i]) reg_rdata[CNT_W-1:0] = cnt_q[i];
    end
  end

  AST_ERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[NUM_PERIPH-1:0] == '0) |-> !irq_err); // R7
  AST_COR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[SW-1:NUM_PERIPH] == '0) |-> !irq_cor); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> (reg_rdata == '0)); // R12
  AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !addr_hit && ecc_err_evt == '0 && ecc_cor_evt == '0)
      |=> ($stable(stat_q) && $stable(en_q))); // R12

endmodule

// File: tb/ecc_irq_unit_tb.sv
module ecc_irq_unit_tb;
  localparam int NP = 4;
  localparam int CW = 3;
  localparam int DW = 32;
  localparam int AW = 3;

  typedef struct packed {
    logic [NP-1:0] err;
    logic [NP-1:0] cor;
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [AW-1:0] chk_addr;
    logic [DW-1:0] exp_rd;
    logic          exp_ie;
    logic          exp_ic;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{4'h1, 4'h0, 1'b0, 3'd0, 32'h00, 3'd0, 32'h01, 1'b0, 1'b0}, // R2 err evt sets bit 0
    '{4'h0, 4'h4, 1'b0, 3'd0, 32'h00, 3'd0, 32'h41, 1'b0, 1'b0}, // R3 cor evt sets bit 6
    '{4'h0, 4'h0, 1'b1, 3'd1, 32'h41, 3'd1, 32'h41, 1'b1, 1'b1}, // R6 R7 enables
    '{4'h0, 4'h0, 1'b1, 3'd0, 32'h01, 3'd0, 32'h40, 1'b0, 1'b1}, // R4 W1C bit 0
    '{4'h2, 4'h0, 1'b0, 3'd0, 32'h00, 3'd0, 32'h42, 1'b0, 1'b1}, // R7 ungated bit
    '{4'h0, 4'h4, 1'b1, 3'd0, 32'h40, 3'd0, 32'h42, 1'b0, 1'b1}, // R5 evt beats clear
    '{4'h0, 4'h0, 1'b1, 3'd0, 32'hFF, 3'd0, 32'h00, 1'b0, 1'b0}, // R4 clear all
    '{4'h8, 4'h8, 1'b0, 3'd0, 32'h00, 3'd5, 32'h01, 1'b0, 1'b0}, // R8 both evts count once
    '{4'h0, 4'h0, 1'b0, 3'd0, 32'h00, 3'd4, 32'h02, 1'b0, 1'b0}, // R8 periph2 count
    '{4'h0, 4'h0, 1'b1, 3'd4, 32'h05, 3'd4, 32'h02, 1'b0, 1'b0}, // R10 nonzero ignored
    '{4'h0, 4'h0, 1'b1, 3'd4, 32'h00, 3'd4, 32'h00, 1'b0, 1'b0}, // R10 zero clears
    '{4'h0, 4'h0, 1'b1, 3'd7, 32'hFF, 3'd7, 32'h00, 1'b0, 1'b0}, // R12 unmapped
    '{4'h1, 4'h0, 1'b1, 3'd2, 32'h00, 3'd2, 32'h01, 1'b1, 1'b0}  // R11 clear+evt
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] ecc_err_evt = '0;
  logic [NP-1:0] ecc_cor_evt = '0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq_err;
  logic          irq_cor;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ecc_irq_unit #(.NUM_PERIPH(NP), .CNT_W(CW), .DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ecc_err_evt(ecc_err_evt), .ecc_cor_evt(ecc_cor_evt),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_err(irq_err), .irq_cor(irq_cor)
  );

  task automatic check(input string req, input logic [DW+1:0] act, input logic [DW+1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got rdata/irqs %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input logic [AW-1:0] a,
                          input logic [DW-1:0] rd, input logic ie, input logic ic);
    reg_addr = a;
    #1;
    check(req, {reg_rdata, irq_err, irq_cor}, {rd, ie, ic});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 6; a++) begin
      read_chk("R1 reset", AW'(a), '0, 1'b0, 1'b0);
    end

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      ecc_err_evt = VEC[v].err;
      ecc_cor_evt = VEC[v].cor;
      reg_we      = VEC[v].we;
      reg_addr    = VEC[v].addr;
      reg_wdata   = VEC[v].wdata;
      @(posedge clk);
      #1;
      ecc_err_evt = '0;
      ecc_cor_evt = '0;
      reg_we      = 1'b0;
      read_chk($sformatf("vector %0d (R2..R12)", v), VEC[v].chk_addr,
               VEC[v].exp_rd, VEC[v].exp_ie, VEC[v].exp_ic);
    end

    // R9: periph1 counter is at 1; ten more events saturate it at 7.
    @(negedge clk);
    ecc_err_evt = 4'h2;
    repeat (10) @(negedge clk);
    ecc_err_evt = '0;
    read_chk("R9 saturation", 3'd3, 32'd7, 1'b1, 1'b0);

    // R4: status now holds bits 0, 1, 3, 7; a zero write keeps them.
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h0;
    @(negedge clk);
    reg_we = 1'b0;
    read_chk("R4 zero write keeps", 3'd0, 32'h8B, 1'b1, 1'b0);

    // R1: reset mid-run returns everything to zero.
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    read_chk("R1 re-reset status", 3'd0, '0, 1'b0, 1'b0);
    read_chk("R1 re-reset enable", 3'd1, '0, 1'b0, 1'b0);
    read_chk("R1 re-reset counter", 3'd3, '0, 1'b0, 1'b0);

    finish_run();
  end
endmodule